// File: doc/BRIEF.md
# Queued-transaction host register and buffer interface

This block is the host side of a bus master channel that runs a list of queued transactions. A host on an 8-bit parallel register bus loads a table of slave addresses, a transaction count, a byte length for each transaction and one shared data buffer. Each of these is loaded through a pointer that advances by itself on every access. The bytes of successive transactions sit back to back in the buffer. The host can pick a transaction and an offset within its region, then overwrite bytes there or read them back.

Writes to the control register clear all pointers together and raise one-cycle requests for an attached bus engine: an immediate start, a stop, or a start armed to wait for an edge on a trigger input. The engine itself lies outside this block. It sees the stored tables and buffer through a combinational read port. For a given slot the port returns the slave byte, its direction bit, the length and the start address of that slot in the buffer. For a given buffer address it returns the byte stored there.

Register addresses: 0 control, 1 slave table, 2 transaction config, 3 transaction select, 4 offset, 5 data. Addresses 6 and 7 are unused.

Top module: `mtb_host_if`

## Requirements
- R1: After reset the block is in the following state: txn_count is 0, overflow is 0, all three request pulses are 0, every stored byte is 0x00, and the config register expects the count byte next.
- R2: Each write to address 1 stores the byte in the slave table at the table pointer, then advances the pointer. eng_sla returns the byte stored for eng_slot. eng_dir is bit 0 of that byte (1 means read, 0 means write).
- R3: After a reset or a pointer clear, the first write to address 2 sets txn_count. Any value above N_TXN is stored as N_TXN. Each later write to address 2 stores the length of the next slot, starting at slot 0. Once the count has been set, it changes again only through this same sequence.
- R4: Each write to address 5 stores the byte at the data pointer, then advances the pointer. eng_base for slot k equals the sum of the lengths of slots 0 to k-1, capped at BUF_BYTES. eng_byte returns the buffer byte at eng_addr.
- R5: A write to address 3 selects the slot given by the low log2(N_TXN) bits of the byte. A write to address 4 then moves the data pointer to the base of the selected slot plus the written offset, capped at BUF_BYTES. Later data accesses continue from that point.
- R6: While reg_rd is high at address 5, reg_rdata shows the byte at the data pointer, and the pointer advances at the clock edge.
- R7: A control write with bit 1 set clears the slave-table pointer, the length pointer and the data pointer, clears overflow, and makes the config register expect the count byte again.
- R8: A control write with bit 6 set and bit 3 clear makes start_pulse high for one cycle. A control write with bit 5 set makes stop_pulse high for one cycle and cancels any armed start.
- R9: A control write with bits 6 and 3 set arms a triggered start. Bit 4 of the same write selects the edge of trig_in (1 rising, 0 falling). On the first selected edge, trig_start_pulse is high for one cycle and the start disarms. Edges of the other polarity have no effect.
- R10: Pointers stop one position past the last entry and do not wrap. A write at a full table, full length list or full buffer stores nothing and sets overflow, which stays set until a pointer clear. A data read at the end of the buffer returns 0x00 and does not move the pointer.
- R11: A read at any address other than 5 returns 0x00 and leaves the data pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Host register address |
| reg_wr | input | 1 | Host write strobe, one access per high cycle |
| reg_rd | input | 1 | Host read strobe, one access per high cycle |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid in the strobe cycle |
| trig_in | input | 1 | Synchronised external start trigger |
| start_pulse | output | 1 | Immediate start request |
| stop_pulse | output | 1 | Stop request |
| trig_start_pulse | output | 1 | Triggered start request |
| txn_count | output | $clog2(N_TXN+1) | Stored transaction count |
| overflow | output | 1 | Sticky write-past-end flag |
| eng_slot | input | $clog2(N_TXN) | Engine slot index |
| eng_sla | output | 8 | Slave byte of eng_slot |
| eng_dir | output | 1 | Direction bit of eng_slot |
| eng_len | output | 8 | Length of eng_slot |
| eng_base | output | $clog2(BUF_BYTES+1) | Buffer start address of eng_slot |
| eng_addr | input | $clog2(BUF_BYTES) | Engine buffer address |
| eng_byte | output | 8 | Buffer byte at eng_addr |

## Verification
The bench builds the block with N_TXN=4 and BUF_BYTES=16. With these sizes, random lengths of 0 to 5 bytes often add up to more than the buffer. Random offsets run past the buffer end, and random streams of slave, length and data writes go past every table end. The saturation, capping and sticky-overflow paths are therefore exercised many times, alongside the ordinary packed-buffer accesses, within a short run. Directed sequences cover the request pulses and both trigger polarities. They also cover an armed start that must ignore edges of the wrong polarity.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 3'd0,
        RA_SLA  = 3'd1,
        RA_CFG  = 3'd2,
        RA_SEL  = 3'd3,
        RA_OFS  = 3'd4,
        RA_DATA = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic wr_ctl;
        logic wr_sla;
        logic wr_cfg;
        logic wr_sel;
        logic wr_ofs;
        logic wr_dat;
        logic rd_dat;
    } host_op_t;

    typedef struct packed {
        logic ptr_clr;
        logic go;
        logic go_trig;
        logic trig_rise;
        logic halt;
    } ctl_cmd_t;

    // A write takes priority over a read issued in the same cycle.
    function automatic host_op_t decode_host(logic [REG_AW-1:0] a, logic wr, logic rd);
        host_op_t op;
        op.wr_ctl = wr && (a == RA_CTRL);
        op.wr_sla = wr && (a == RA_SLA);
        op.wr_cfg = wr && (a == RA_CFG);
        op.wr_sel = wr && (a == RA_SEL);
        op.wr_ofs = wr && (a == RA_OFS);
        op.wr_dat = wr && (a == RA_DATA);
        op.rd_dat = rd && !wr && (a == RA_DATA);
        return op;
    endfunction

    function automatic ctl_cmd_t decode_ctl(logic valid, logic [7:0] b);
        ctl_cmd_t c;
        c.ptr_clr   = valid && b[1];
        c.go        = valid && b[6] && !b[3];
        c.go_trig   = valid && b[6] && b[3];
        c.trig_rise = b[4];
        c.halt      = valid && b[5];
        return c;
    endfunction

endpackage

// File: rtl/mtb_txn_tables.sv
module mtb_txn_tables #(
    parameter int N_TXN = 8,
    localparam int SLOT_W = $clog2(N_TXN),
    localparam int CNT_W  = $clog2(N_TXN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ptr_clr,
    input  logic                  wr_sla,
    input  logic                  wr_cfg,
    input  logic [7:0]            wdata,
    output logic                  ov_evt,
    output logic [CNT_W-1:0]      txn_count,
    output logic [N_TXN-1:0][7:0] len_q,
    input  logic [SLOT_W-1:0]     eng_slot,
    output logic [7:0]            eng_sla,
    output logic [7:0]            eng_len
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(N_TXN);

    logic [N_TXN-1:0][7:0] sla_q;
    logic [CNT_W-1:0]      sptr, lptr;
    logic                  want_cnt;

    logic sla_full, len_full;
    assign sla_full = (sptr == FULL);
    assign len_full = (lptr == FULL);
    assign ov_evt   = (wr_sla && sla_full) || (wr_cfg && !want_cnt && len_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            sla_q     <= '0;
            len_q     <= '0;
            sptr      <= '0;
            lptr      <= '0;
            want_cnt  <= 1'b1;
            txn_count <= '0;
        end else if (ptr_clr) begin
            sptr     <= '0;
            lptr     <= '0;
            want_cnt <= 1'b1;
        end else begin
            if (wr_sla && !sla_full) begin
                sla_q[sptr[SLOT_W-1:0]] <= wdata;
                sptr <= sptr + CNT_W'(1);
            end
            if (wr_cfg) begin
                if (want_cnt) begin
                    txn_count <= (wdata > 8'(N_TXN)) ? FULL : wdata[CNT_W-1:0];
                    want_cnt  <= 1'b0;
                end else if (!len_full) begin
                    len_q[lptr[SLOT_W-1:0]] <= wdata;
                    lptr <= lptr + CNT_W'(1);
                end
            end
        end
    end

    assign eng_sla = sla_q[eng_slot];
    assign eng_len = len_q[eng_slot];

    p_count_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!want_cnt && !ptr_clr) |=> $stable(txn_count));
    p_sla_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (sla_full && !ptr_clr) |=> sla_full);
    p_len_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (len_full && !ptr_clr) |=> len_full);

endmodule

// File: rtl/mtb_data_buf.sv
module mtb_data_buf #(
    parameter int N_TXN     = 8,
    parameter int BUF_BYTES = 64,
    localparam int SLOT_W  = $clog2(N_TXN),
    localparam int BPTR_W  = $clog2(BUF_BYTES + 1),
    localparam int BADDR_W = $clog2(BUF_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ptr_clr,
    input  logic                  wr_dat,
    input  logic                  rd_dat,
    input  logic                  wr_sel,
    input  logic                  wr_ofs,
    input  logic [7:0]            wdata,
    input  logic [N_TXN-1:0][7:0] len_q,
    output logic [7:0]            rdata,
    output logic                  ov_evt,
    input  logic [SLOT_W-1:0]     eng_slot,
    output logic [BPTR_W-1:0]     eng_base,
    input  logic [BADDR_W-1:0]    eng_addr,
    output logic [7:0]            eng_byte
);
    localparam int SUM_W = 8 + SLOT_W + 1;
    localparam logic [BPTR_W-1:0] END_PTR = BPTR_W'(BUF_BYTES);

    logic [BUF_BYTES-1:0][7:0] mem;
    logic [BPTR_W-1:0]         dptr;
    logic [SLOT_W-1:0]         sel;
    logic [SUM_W-1:0]          pre [N_TXN+1];

    function automatic logic [BPTR_W-1:0] cap(logic [SUM_W-1:0] v);
        return (v > SUM_W'(BUF_BYTES)) ? END_PTR : BPTR_W'(v);
    endfunction

    // Running sum of lengths: pre[k] is where slot k starts.
    assign pre[0] = '0;
    for (genvar k = 0; k < N_TXN; k++) begin : g_prefix
        assign pre[k+1] = pre[k] + SUM_W'(len_q[k]);
    end

    logic at_end;
    logic [BPTR_W-1:0] seek_ptr;
    assign at_end   = (dptr == END_PTR);
    assign seek_ptr = cap(pre[sel] + SUM_W'(wdata));
    assign ov_evt   = wr_dat && at_end;
    assign rdata    = at_end ? 8'h00 : mem[dptr[BADDR_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem  <= '0;
            dptr <= '0;
            sel  <= '0;
        end else begin
            if (wr_sel) sel <= wdata[SLOT_W-1:0];
            if (ptr_clr) begin
                dptr <= '0;
            end else if (wr_ofs) begin
                dptr <= seek_ptr;
            end else if (wr_dat) begin
                if (!at_end) begin
                    mem[dptr[BADDR_W-1:0]] <= wdata;
                    dptr <= dptr + BPTR_W'(1);
                end
            end else if (rd_dat && !at_end) begin
                dptr <= dptr + BPTR_W'(1);
            end
        end
    end

    assign eng_base = cap(pre[eng_slot]);
    assign eng_byte = mem[eng_addr];

    p_end_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (at_end && !ptr_clr && !wr_ofs) |=> at_end);
    p_read_step_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_dat && !at_end && !ptr_clr && !wr_ofs && !wr_dat) |=> (dptr == $past(dptr) + BPTR_W'(1)));
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ptr_clr |=> (dptr == '0));

endmodule

// File: rtl/mtb_start_ctl.sv
module mtb_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic go_trig,
    input  logic trig_rise,
    input  logic halt,
    input  logic trig_in,
    output logic start_pulse,
    output logic stop_pulse,
    output logic trig_start_pulse
);
    logic trig_q, armed, pol_rise;
    logic edge_up, edge_dn, hit;

    assign edge_up = trig_in && !trig_q;
    assign edge_dn = !trig_in && trig_q;
    assign hit     = armed && (pol_rise ? edge_up : edge_dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q           <= 1'b0;
            armed            <= 1'b0;
            pol_rise         <= 1'b0;
            start_pulse      <= 1'b0;
            stop_pulse       <= 1'b0;
            trig_start_pulse <= 1'b0;
        end else begin
            trig_q           <= trig_in;
            start_pulse      <= go;
            stop_pulse       <= halt;
            trig_start_pulse <= hit;
            if (go_trig) begin
                armed    <= 1'b1;
                pol_rise <= trig_rise;
            end else if (hit || halt) begin
                armed <= 1'b0;
            end
        end
    end

    p_trig_needs_arm_r9: assert property (@(posedge clk) disable iff (rst)
        trig_start_pulse |-> $past(armed));
    p_trig_once_r9: assert property (@(posedge clk) disable iff (rst)
        (trig_start_pulse && !$past(go_trig)) |-> !armed);
    p_stop_disarm_r8: assert property (@(posedge clk) disable iff (rst)
        (halt && !go_trig) |=> !armed);

endmodule

// File: rtl/mtb_host_if.sv
module mtb_host_if
    import mtb_pkg::*;
#(
    parameter int N_TXN     = 8,
    parameter int BUF_BYTES = 64,
    localparam int SLOT_W  = $clog2(N_TXN),
    localparam int CNT_W   = $clog2(N_TXN + 1),
    localparam int BPTR_W  = $clog2(BUF_BYTES + 1),
    localparam int BADDR_W = $clog2(BUF_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               trig_in,
    output logic               start_pulse,
    output logic               stop_pulse,
    output logic               trig_start_pulse,
    output logic [CNT_W-1:0]   txn_count,
    output logic               overflow,
    input  logic [SLOT_W-1:0]  eng_slot,
    output logic [7:0]         eng_sla,
    output logic               eng_dir,
    output logic [7:0]         eng_len,
    output logic [BPTR_W-1:0]  eng_base,
    input  logic [BADDR_W-1:0] eng_addr,
    output logic [7:0]         eng_byte
);
    host_op_t op;
    ctl_cmd_t cmd;
    assign op  = decode_host(reg_addr, reg_wr, reg_rd);
    assign cmd = decode_ctl(op.wr_ctl, reg_wdata);

    logic [N_TXN-1:0][7:0] len_q;
    logic                  tab_ov, buf_ov;
    logic [7:0]            buf_rdata;

    mtb_txn_tables #(.N_TXN(N_TXN)) u_tab (
        .clk(clk), .rst(rst), .ptr_clr(cmd.ptr_clr),
        .wr_sla(op.wr_sla), .wr_cfg(op.wr_cfg), .wdata(reg_wdata),
        .ov_evt(tab_ov), .txn_count(txn_count), .len_q(len_q),
        .eng_slot(eng_slot), .eng_sla(eng_sla), .eng_len(eng_len)
    );

    mtb_data_buf #(.N_TXN(N_TXN), .BUF_BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .rst(rst), .ptr_clr(cmd.ptr_clr),
        .wr_dat(op.wr_dat), .rd_dat(op.rd_dat), .wr_sel(op.wr_sel),
        .wr_ofs(op.wr_ofs), .wdata(reg_wdata), .len_q(len_q),
        .rdata(buf_rdata), .ov_evt(buf_ov),
        .eng_slot(eng_slot), .eng_base(eng_base),
        .eng_addr(eng_addr), .eng_byte(eng_byte)
    );

    mtb_start_ctl u_go (
        .clk(clk), .rst(rst), .go(cmd.go), .go_trig(cmd.go_trig),
        .trig_rise(cmd.trig_rise), .halt(cmd.halt), .trig_in(trig_in),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .trig_start_pulse(trig_start_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.ptr_clr) overflow <= 1'b0;
        else if (tab_ov || buf_ov) overflow <= 1'b1;
    end

    assign eng_dir   = eng_sla[0];
    assign reg_rdata = op.rd_dat ? buf_rdata : 8'h00;

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (overflow && !cmd.ptr_clr) |=> overflow);
    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (rst)
        cmd.ptr_clr |=> !overflow);
    p_pulses_excl_r8: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(reg_wr));

endmodule

// File: tb/sim_mtb_host_if.sv
module sim_mtb_host_if;
    localparam int NT = 4;
    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       trig_in = 1'b0;
    logic       start_pulse, stop_pulse, trig_start_pulse;
    logic [2:0] txn_count;
    logic       overflow;
    logic [1:0] eng_slot = '0;
    logic [7:0] eng_sla, eng_len, eng_byte;
    logic       eng_dir;
    logic [4:0] eng_base;
    logic [3:0] eng_addr = '0;

    always #4 clk = ~clk;

    mtb_host_if #(.N_TXN(NT), .BUF_BYTES(NB)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig_in(trig_in), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .trig_start_pulse(trig_start_pulse), .txn_count(txn_count),
        .overflow(overflow), .eng_slot(eng_slot), .eng_sla(eng_sla),
        .eng_dir(eng_dir), .eng_len(eng_len), .eng_base(eng_base),
        .eng_addr(eng_addr), .eng_byte(eng_byte)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_sla [NT];
    logic [7:0] m_len [NT];
    logic [7:0] m_buf [NB];
    int m_cnt, m_sp, m_lp, m_dp, m_sel;
    bit m_first, m_ov;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int m_base(int k);
        int s = 0;
        for (int i = 0; i < k; i++) s += m_len[i];
        return (s > NB) ? NB : s;
    endfunction

    task automatic model_wr(int a, int d);
        case (a)
            0: if (d[1]) begin m_sp = 0; m_lp = 0; m_dp = 0; m_first = 1; m_ov = 0; end
            1: if (m_sp < NT) begin m_sla[m_sp] = 8'(d); m_sp++; end else m_ov = 1;
            2: if (m_first) begin m_cnt = (d > NT) ? NT : d; m_first = 0; end
               else if (m_lp < NT) begin m_len[m_lp] = 8'(d); m_lp++; end else m_ov = 1;
            3: m_sel = d % NT;
            4: begin m_dp = m_base(m_sel) + d; if (m_dp > NB) m_dp = NB; end
            5: if (m_dp < NB) begin m_buf[m_dp] = 8'(d); m_dp++; end else m_ov = 1;
            default: ;
        endcase
    endtask

    task automatic hw_wr(int a, int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic hw_rd(int a, output int v);
        @(negedge clk);
        reg_addr = 3'(a); reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // Data read checked against the reference
    task automatic rd_data_chk(string req);
        int v, e;
        hw_rd(5, v);
        if (m_dp < NB) begin e = m_buf[m_dp]; m_dp++; end else e = 0;
        chk(req, v, e);
    endtask

    task automatic eng_dump_chk(string req);
        for (int k = 0; k < NT; k++) begin
            eng_slot = 2'(k); #1;
            chk({req, " sla"}, eng_sla, m_sla[k]);
            chk({req, " dir"}, eng_dir, m_sla[k][0]);
            chk({req, " len"}, eng_len, m_len[k]);
            chk({req, " base"}, eng_base, m_base(k));
        end
        for (int i = 0; i < NB; i++) begin
            eng_addr = 4'(i); #1;
            chk({req, " byte"}, eng_byte, m_buf[i]);
        end
    endtask

    task automatic set_trig(bit t);
        @(negedge clk); trig_in = t;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd24680));
        for (int i = 0; i < NT; i++) begin m_sla[i] = 0; m_len[i] = 0; end
        for (int i = 0; i < NB; i++) m_buf[i] = 0;
        m_cnt = 0; m_sp = 0; m_lp = 0; m_dp = 0; m_sel = 0; m_first = 1; m_ov = 0;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 count", txn_count, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 pulses", {start_pulse, stop_pulse, trig_start_pulse}, 0);
        eng_dump_chk("R1 stored");

        // R2/R3/R4 directed load
        hw_wr(0, 8'h02);
        hw_wr(1, 8'hA0); hw_wr(1, 8'h51); hw_wr(1, 8'h3C);
        hw_wr(2, 3); hw_wr(2, 2); hw_wr(2, 3); hw_wr(2, 4);
        for (int i = 0; i < 9; i++) hw_wr(5, 8'h10 + i);
        chk("R3 count", txn_count, 3);
        eng_slot = 2'd1; #1;
        chk("R2 dir read", eng_dir, 1);
        chk("R4 base slot1", eng_base, 2);
        eng_slot = 2'd2; #1;
        chk("R4 base slot2", eng_base, 5);
        eng_dump_chk("R4 packed");

        // R5/R6 select and offset
        hw_wr(3, 1); hw_wr(4, 1);
        hw_rd(5, v); m_dp++; chk("R6 read slot1+1", v, 8'h13);
        hw_rd(5, v); m_dp++; chk("R6 read advance", v, 8'h14);
        hw_wr(3, 2); hw_wr(4, 0); hw_wr(5, 8'hEE);
        eng_addr = 4'd5; #1;
        chk("R5 overwrite", eng_byte, 8'hEE);

        // R11 unused and non-data reads
        hw_rd(6, v); chk("R11 unused", v, 0);
        hw_rd(1, v); chk("R11 slave addr", v, 0);
        hw_rd(0, v); chk("R11 control", v, 0);
        rd_data_chk("R11 pointer kept");

        // R3 count saturation, R10 table overflow
        hw_wr(0, 8'h02);
        hw_wr(2, 9);
        chk("R3 count sat", txn_count, NT);
        for (int i = 0; i < NT + 1; i++) hw_wr(1, 8'hB0 + i);
        chk("R10 slave overflow", overflow, 1);
        eng_slot = 2'd0; #1;
        chk("R10 no wrap", eng_sla, 8'hB0);
        hw_wr(0, 8'h02);
        chk("R7 overflow clear", overflow, 0);

        // R10 buffer end
        for (int i = 0; i < NB + 1; i++) hw_wr(5, 8'h60 + i);
        chk("R10 data overflow", overflow, 1);
        rd_data_chk("R10 read at end");
        hw_wr(1, 8'h77);
        chk("R10 sticky", overflow, 1);
        hw_wr(0, 8'h02);
        rd_data_chk("R7 data ptr cleared");

        // R8 pulses
        hw_wr(0, 8'h40);
        chk("R8 start", start_pulse, 1);
        @(posedge clk); #1;
        chk("R8 start single", start_pulse, 0);
        hw_wr(0, 8'h20);
        chk("R8 stop", stop_pulse, 1);
        chk("R8 stop no start", start_pulse, 0);

        // R9 rising trigger
        hw_wr(0, 8'h58);
        chk("R9 armed no immediate start", start_pulse | trig_start_pulse, 0);
        set_trig(1);
        chk("R9 rise fires", trig_start_pulse, 1);
        @(posedge clk); #1;
        chk("R9 single", trig_start_pulse, 0);
        set_trig(0); set_trig(1);
        chk("R9 disarmed", trig_start_pulse, 0);
        // R9 falling trigger ignores rising
        set_trig(0);
        hw_wr(0, 8'h48);
        set_trig(1);
        chk("R9 wrong edge", trig_start_pulse, 0);
        set_trig(0);
        chk("R9 fall fires", trig_start_pulse, 1);
        // R8 stop cancels armed start
        hw_wr(0, 8'h48);
        hw_wr(0, 8'h20);
        set_trig(1); set_trig(0);
        chk("R8 stop cancels", trig_start_pulse, 0);

        // Random mixed accesses
        for (int n = 0; n < 400; n++) begin
            int op = $urandom % 16;
            if (op == 0)      hw_wr(0, 8'h02);
            else if (op < 3)  hw_wr(1, $urandom % 256);
            else if (op < 6)  hw_wr(2, $urandom % 6);
            else if (op < 10) hw_wr(5, $urandom % 256);
            else if (op < 11) hw_wr(3, $urandom % NT);
            else if (op < 12) hw_wr(4, $urandom % 20);
            else              rd_data_chk("R6 random read");
            chk("R10 random overflow", overflow, m_ov);
            chk("R3 random count", txn_count, m_cnt);
        end
        eng_dump_chk("R4 random final");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule